// File: doc/BRIEF.md
# Memory-Map Address Decoder

This block sits between an 8-bit CPU bus with a 16-bit address and the memories and register files behind it. For every byte access it works out which target owns the address, raises that target's chip select, and hands the target a local offset cut from the address. The same decode steers a read multiplexer that returns the chosen target's byte. Chip selects, offsets and read data are combinational within the access cycle. The targets are: a fixed ROM window, a switchable ROM window, video RAM, two work-RAM banks, and an I/O register port. A write into either ROM window is routed to the bank controller as a write strobe. The controller takes the address and data from the CPU bus itself.

Two small stores live inside the block: a 127-byte high-speed scratch RAM and an 8-bit interrupt-enable register. Both are written on the clock edge and clear on reset. The external-RAM window and the sprite-attribute window are stubs: they read as zero and drop writes. Work RAM appears twice, because bank 0 has an echo copy and bank 1 has an echo copy that stops short of the sprite-attribute area. A write to video RAM also produces a one-cycle notify pulse on the next cycle, carrying the offset written, so a renderer can invalidate cached tiles.

Top module: `memmap_decoder`

## Requirements
- R1: A read with bus_addr in 0x0000–0x3FFF asserts rom_lo_cs and returns rom_lo_rdata. A read in 0x4000–0x7FFF asserts rom_hi_cs and returns rom_hi_rdata. In both windows rom_offs equals bus_addr[13:0].
- R2: A write with bus_addr in 0x0000–0x7FFF asserts bank_wr and neither ROM chip select. bank_wr is never high for any other access.
- R3: An access in 0x8000–0x9FFF asserts vram_cs with vram_offs equal to bus_addr[12:0]. A read there returns vram_rdata.
- R4: A write in 0x8000–0x9FFF makes vram_note high for exactly the following cycle, with vram_note_offs equal to the written bus_addr[12:0]. vram_note is low after any other access and after reset.
- R5: A read in 0xA000–0xBFFF returns 0x00 and raises no chip select. A write there raises no chip select.
- R6: Accesses in 0xC000–0xCFFF and in the echo range 0xE000–0xEFFF assert wram0_cs with wram_offs equal to bus_addr[11:0]. A read returns wram0_rdata.
- R7: Accesses in 0xD000–0xDFFF and in the echo range 0xF000–0xFDFF assert wram1_cs with wram_offs equal to bus_addr[11:0]. A read returns wram1_rdata.
- R8: A read in 0xFE00–0xFEFF returns 0x00 and raises no chip select. A write there raises no chip select.
- R9: Accesses in 0xFF00–0xFF7F assert io_cs with io_offs equal to bus_addr[6:0]. A read returns io_rdata.
- R10: 0xFF80–0xFFFE is internal scratch RAM at index bus_addr[6:0]. A written byte reads back on any later read of the same address. Reset clears every byte to 0x00.
- R11: 0xFFFF is an internal 8-bit interrupt-enable register. It reads back the last byte written and resets to 0x00.
- R12: At most one chip select (including bank_wr) is high in any cycle. With bus_req low, no chip select is high, bus_rdata is 0x00 and no internal store changes. bus_rdata is also 0x00 during writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the current access |
| rom_lo_cs | output | 1 | Fixed ROM window read select |
| rom_hi_cs | output | 1 | Switchable ROM window read select |
| rom_offs | output | 14 | Offset inside a ROM window |
| rom_lo_rdata | input | DATA_W | Fixed ROM read byte |
| rom_hi_rdata | input | DATA_W | Switchable ROM read byte |
| bank_wr | output | 1 | Write strobe to the bank controller |
| vram_cs | output | 1 | Video RAM select |
| vram_offs | output | 13 | Video RAM offset |
| vram_rdata | input | DATA_W | Video RAM read byte |
| vram_note | output | 1 | One-cycle pulse after a video RAM write |
| vram_note_offs | output | 13 | Offset of that write |
| wram0_cs | output | 1 | Work RAM bank 0 select |
| wram1_cs | output | 1 | Work RAM bank 1 select |
| wram_offs | output | 12 | Work RAM offset |
| wram0_rdata | input | DATA_W | Bank 0 read byte |
| wram1_rdata | input | DATA_W | Bank 1 read byte |
| io_cs | output | 1 | I/O register port select |
| io_offs | output | IO_OW | I/O register offset |
| io_rdata | input | DATA_W | I/O read byte |

## Verification
On every cycle the assertions check several properties: the chip selects are mutually exclusive and silent when idle, the stub windows read zero, the echo range lands on bank 0, bank writes only come from the lower half, and each video RAM write is followed by a matching notify pulse and nothing else raises one. Other behaviour depends on stored state over long stretches, and only the bench's scenarios show it. This covers scratch-RAM contents surviving across unrelated traffic, their clearing by a second reset, writes with bus_req low leaving them untouched, and the exact offset and data routing at each side of every region boundary.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
   // region slot numbers; the read mux and the selects index by these
   localparam int RG_ROM0  = 0;
   localparam int RG_ROM1  = 1;
   localparam int RG_VRAM  = 2;
   localparam int RG_XRAM  = 3;
   localparam int RG_WRAM0 = 4;
   localparam int RG_WRAM1 = 5;
   localparam int RG_OAM   = 6;
   localparam int RG_IO    = 7;
   localparam int RG_HRAM  = 8;
   localparam int RG_IE    = 9;
   localparam int NUM_RGN  = 10;

   // fine-grained boundaries inside the top 4 KiB page
   localparam logic [15:0] OAM_BASE  = 16'hFE00;
   localparam logic [15:0] IO_BASE   = 16'hFF00;
   localparam logic [15:0] HRAM_BASE = 16'hFF80;
   localparam logic [15:0] IE_ADDR   = 16'hFFFF;
endpackage

// File: rtl/mm_region_decode.sv
module mm_region_decode
   import memmap_pkg::*;
(
   input  logic [15:0]        addr,
   output logic [NUM_RGN-1:0] hit
);
   always_comb begin
      hit = '0;
      case (addr[15:12])
         4'h0, 4'h1, 4'h2, 4'h3: hit[RG_ROM0]  = 1'b1;
         4'h4, 4'h5, 4'h6, 4'h7: hit[RG_ROM1]  = 1'b1;
         4'h8, 4'h9:             hit[RG_VRAM]  = 1'b1;
         4'hA, 4'hB:             hit[RG_XRAM]  = 1'b1;
         4'hC, 4'hE:             hit[RG_WRAM0] = 1'b1;
         4'hD:                   hit[RG_WRAM1] = 1'b1;
         default: begin
            if (addr < OAM_BASE)       hit[RG_WRAM1] = 1'b1;
            else if (addr < IO_BASE)   hit[RG_OAM]   = 1'b1;
            else if (addr < HRAM_BASE) hit[RG_IO]    = 1'b1;
            else if (addr != IE_ADDR)  hit[RG_HRAM]  = 1'b1;
            else                       hit[RG_IE]    = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/mm_hram_store.sv
module mm_hram_store #(
   parameter int DW    = 8,
   parameter int DEPTH = 127,
   parameter int IW    = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [IW-1:0] idx,
   input  logic          ie_wr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rd_q,
   output logic [DW-1:0] ie_q
);
   localparam logic [IW:0] DEPTH_V = (IW+1)'(DEPTH);

   logic [DW-1:0] mem [DEPTH];
   logic          in_range;

   assign in_range = ({1'b0, idx} < DEPTH_V);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         ie_q <= '0;
      end else begin
         if (wr_en && in_range) mem[idx] <= wdata;
         if (ie_wr) ie_q <= wdata;
      end
   end

   assign rd_q = in_range ? mem[idx] : '0;
endmodule

// File: rtl/mm_rdata_mux.sv
module mm_rdata_mux #(
   parameter int DW = 8,
   parameter int N  = 10
) (
   input  logic [N-1:0]         pick,
   input  logic [N-1:0][DW-1:0] src,
   output logic [DW-1:0]        q
);
   logic [N-1:0][DW-1:0] term;

   // AND-OR tree: pick is one-hot or zero, so no priority is needed
   for (genvar g = 0; g < N; g++) begin : g_term
      assign term[g] = src[g] & {DW{pick[g]}};
   end

   always_comb begin
      q = '0;
      for (int i = 0; i < N; i++) q = q | term[i];
   end
endmodule

// File: rtl/mm_vram_notify.sv
module mm_vram_notify #(
   parameter int OW         = 13,
   parameter bit REGISTERED = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [OW-1:0] offs,
   output logic          note,
   output logic [OW-1:0] note_offs
);
   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            note      <= 1'b0;
            note_offs <= '0;
         end else begin
            note      <= wr;
            note_offs <= offs;
         end
      end
   end else begin : g_comb
      assign note      = wr;
      assign note_offs = offs;
   end
endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
   import memmap_pkg::*;
#(
   parameter int  DATA_W     = 8,
   parameter int  HRAM_DEPTH = 127,
   parameter int  IO_SPAN    = 128,
   parameter bit  NOTIFY_REG = 1'b1,
   localparam int IO_OW      = $clog2(IO_SPAN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [15:0]       bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              rom_lo_cs,
   output logic              rom_hi_cs,
   output logic [13:0]       rom_offs,
   input  logic [DATA_W-1:0] rom_lo_rdata,
   input  logic [DATA_W-1:0] rom_hi_rdata,
   output logic              bank_wr,
   output logic              vram_cs,
   output logic [12:0]       vram_offs,
   input  logic [DATA_W-1:0] vram_rdata,
   output logic              vram_note,
   output logic [12:0]       vram_note_offs,
   output logic              wram0_cs,
   output logic              wram1_cs,
   output logic [11:0]       wram_offs,
   input  logic [DATA_W-1:0] wram0_rdata,
   input  logic [DATA_W-1:0] wram1_rdata,
   output logic              io_cs,
   output logic [IO_OW-1:0]  io_offs,
   input  logic [DATA_W-1:0] io_rdata
);
   localparam int HRAM_IW = 7;

   initial begin
      assert (DATA_W >= 1) else $error("DATA_W must be positive");
      assert (HRAM_DEPTH >= 1 && HRAM_DEPTH <= 127)
         else $error("HRAM_DEPTH must lie in 1..127");
      assert (IO_SPAN >= 2 && IO_SPAN <= 128 && (IO_SPAN & (IO_SPAN - 1)) == 0)
         else $error("IO_SPAN must be a power of two up to 128");
   end

   logic [NUM_RGN-1:0]             hit;
   logic [NUM_RGN-1:0]             rd_pick;
   logic [NUM_RGN-1:0][DATA_W-1:0] src;
   logic                           rd, wr;
   logic [DATA_W-1:0]              hram_q, ie_q;

   mm_region_decode u_dec (.addr(bus_addr), .hit(hit));

   assign rd = bus_req & ~bus_we;
   assign wr = bus_req &  bus_we;

   assign rom_lo_cs = rd & hit[RG_ROM0];
   assign rom_hi_cs = rd & hit[RG_ROM1];
   assign bank_wr   = wr & (hit[RG_ROM0] | hit[RG_ROM1]);
   assign vram_cs   = bus_req & hit[RG_VRAM];
   assign wram0_cs  = bus_req & hit[RG_WRAM0];
   assign wram1_cs  = bus_req & hit[RG_WRAM1];
   assign io_cs     = bus_req & hit[RG_IO];

   assign rom_offs  = bus_addr[13:0];
   assign vram_offs = bus_addr[12:0];
   assign wram_offs = bus_addr[11:0];
   assign io_offs   = bus_addr[IO_OW-1:0];

   mm_hram_store #(.DW(DATA_W), .DEPTH(HRAM_DEPTH), .IW(HRAM_IW)) u_hram (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr & hit[RG_HRAM]),
      .idx   (bus_addr[HRAM_IW-1:0]),
      .ie_wr (wr & hit[RG_IE]),
      .wdata (bus_wdata),
      .rd_q  (hram_q),
      .ie_q  (ie_q)
   );

   always_comb begin
      src           = '0;
      src[RG_ROM0]  = rom_lo_rdata;
      src[RG_ROM1]  = rom_hi_rdata;
      src[RG_VRAM]  = vram_rdata;
      src[RG_WRAM0] = wram0_rdata;
      src[RG_WRAM1] = wram1_rdata;
      src[RG_IO]    = io_rdata;
      src[RG_HRAM]  = hram_q;
      src[RG_IE]    = ie_q;
   end

   assign rd_pick = hit & {NUM_RGN{rd}};

   mm_rdata_mux #(.DW(DATA_W), .N(NUM_RGN)) u_mux (
      .pick (rd_pick),
      .src  (src),
      .q    (bus_rdata)
   );

   mm_vram_notify #(.OW(13), .REGISTERED(NOTIFY_REG)) u_note (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (wr & hit[RG_VRAM]),
      .offs      (bus_addr[12:0]),
      .note      (vram_note),
      .note_offs (vram_note_offs)
   );
endmodule

// File: rtl/memmap_decoder_chk.sv
module memmap_decoder_chk #(
   parameter int  DATA_W     = 8,
   parameter bit  NOTIFY_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_we,
   input logic [15:0]       bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              rom_lo_cs,
   input logic              rom_hi_cs,
   input logic              bank_wr,
   input logic              vram_cs,
   input logic              vram_note,
   input logic [12:0]       vram_note_offs,
   input logic              wram0_cs,
   input logic              wram1_cs,
   input logic [11:0]       wram_offs,
   input logic              io_cs
);
   logic [6:0] cs_all;
   logic       in_vram, in_xram, in_oam, in_echo0, at_ie;

   assign cs_all   = {rom_lo_cs, rom_hi_cs, bank_wr, vram_cs, wram0_cs, wram1_cs, io_cs};
   assign in_vram  = (bus_addr >= 16'h8000) && (bus_addr <= 16'h9FFF);
   assign in_xram  = (bus_addr >= 16'hA000) && (bus_addr <= 16'hBFFF);
   assign in_oam   = (bus_addr >= 16'hFE00) && (bus_addr <= 16'hFEFF);
   assign in_echo0 = (bus_addr >= 16'hE000) && (bus_addr <= 16'hEFFF);
   assign at_ie    = (bus_addr == 16'hFFFF);

   p_cs_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs_all));

   p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_req |-> (cs_all == '0) && (bus_rdata == '0));

   p_bank_lower_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bank_wr |-> bus_we && !bus_addr[15]);

   p_xram_stub_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && in_xram) |-> (cs_all == '0) && (bus_rdata == '0));

   p_oam_stub_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && in_oam) |-> (cs_all == '0) && (bus_rdata == '0));

   p_echo_bank0_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && in_echo0) |-> wram0_cs && (wram_offs == bus_addr[11:0]));

   p_ie_readback_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(bus_req && bus_we && at_ie) && bus_req && !bus_we && at_ie)
      |-> (bus_rdata == $past(bus_wdata)));

   if (NOTIFY_REG) begin : g_note_chk
      p_note_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_req && bus_we && in_vram) |=>
         vram_note && (vram_note_offs == $past(bus_addr[12:0])));

      p_note_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (vram_note && $past(rst_n)) |-> $past(bus_req && bus_we && in_vram));
   end
endmodule

bind memmap_decoder memmap_decoder_chk #(.DATA_W(DATA_W), .NOTIFY_REG(NOTIFY_REG)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .bus_req        (bus_req),
   .bus_we         (bus_we),
   .bus_addr       (bus_addr),
   .bus_wdata      (bus_wdata),
   .bus_rdata      (bus_rdata),
   .rom_lo_cs      (rom_lo_cs),
   .rom_hi_cs      (rom_hi_cs),
   .bank_wr        (bank_wr),
   .vram_cs        (vram_cs),
   .vram_note      (vram_note),
   .vram_note_offs (vram_note_offs),
   .wram0_cs       (wram0_cs),
   .wram1_cs       (wram1_cs),
   .wram_offs      (wram_offs),
   .io_cs          (io_cs)
);

// File: tb/memmap_decoder_test.sv
`timescale 1ns/1ps
module memmap_decoder_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0, bus_we = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        rom_lo_cs, rom_hi_cs, bank_wr, vram_cs, vram_note;
   logic        wram0_cs, wram1_cs, io_cs;
   logic [13:0] rom_offs;
   logic [12:0] vram_offs, vram_note_offs;
   logic [11:0] wram_offs;
   logic [6:0]  io_offs;
   logic [7:0]  rom_lo_rdata, rom_hi_rdata, vram_rdata, wram0_rdata, wram1_rdata, io_rdata;

   int checks = 0;
   int errors = 0;
   logic [7:0] hram_m [127];
   logic [7:0] ie_m;
   bit done = 1'b0;

   always #10 clk = ~clk;

   // each target answers with a byte derived from the offset it was given
   assign rom_lo_rdata = rom_offs[7:0] ^ 8'hA1;
   assign rom_hi_rdata = rom_offs[7:0] ^ 8'hB2;
   assign vram_rdata   = vram_offs[7:0] ^ 8'hC3;
   assign wram0_rdata  = wram_offs[7:0] ^ 8'hD4;
   assign wram1_rdata  = wram_offs[7:0] ^ 8'hE5;
   assign io_rdata     = {1'b0, io_offs} ^ 8'h96;

   memmap_decoder uut (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rom_lo_cs(rom_lo_cs), .rom_hi_cs(rom_hi_cs), .rom_offs(rom_offs),
      .rom_lo_rdata(rom_lo_rdata), .rom_hi_rdata(rom_hi_rdata), .bank_wr(bank_wr),
      .vram_cs(vram_cs), .vram_offs(vram_offs), .vram_rdata(vram_rdata),
      .vram_note(vram_note), .vram_note_offs(vram_note_offs),
      .wram0_cs(wram0_cs), .wram1_cs(wram1_cs), .wram_offs(wram_offs),
      .wram0_rdata(wram0_rdata), .wram1_rdata(wram1_rdata),
      .io_cs(io_cs), .io_offs(io_offs), .io_rdata(io_rdata)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // 0 rom-lo 1 rom-hi 2 vram 3 xram 4 wram0 5 wram1 6 oam 7 io 8 hram 9 ie
   function automatic int zone(input logic [15:0] a);
      if (a <= 16'h3FFF) return 0;
      if (a <= 16'h7FFF) return 1;
      if (a <= 16'h9FFF) return 2;
      if (a <= 16'hBFFF) return 3;
      if (a <= 16'hCFFF) return 4;
      if (a <= 16'hDFFF) return 5;
      if (a <= 16'hEFFF) return 4;
      if (a <= 16'hFDFF) return 5;
      if (a <= 16'hFEFF) return 6;
      if (a <= 16'hFF7F) return 7;
      if (a <= 16'hFFFE) return 8;
      return 9;
   endfunction

   function automatic string tag(input int z, input bit we);
      case (z)
         0, 1: return we ? "R2" : "R1";
         2: return "R3";
         3: return "R5";
         4: return "R6";
         5: return "R7";
         6: return "R8";
         7: return "R9";
         8: return "R10";
         default: return "R11";
      endcase
   endfunction

   function automatic logic [7:0] exp_read(input logic [15:0] a);
      case (zone(a))
         0: return a[7:0] ^ 8'hA1;
         1: return a[7:0] ^ 8'hB2;
         2: return a[7:0] ^ 8'hC3;
         4: return a[7:0] ^ 8'hD4;
         5: return a[7:0] ^ 8'hE5;
         7: return {1'b0, a[6:0]} ^ 8'h96;
         8: return hram_m[a - 16'hFF80];
         9: return ie_m;
         default: return 8'h00;
      endcase
   endfunction

   task automatic acc(input logic [15:0] a, input bit we, input logic [7:0] d, input bit req);
      int z;
      logic [6:0] ecs, acs;
      bit exp_note;
      bus_addr = a; bus_we = we; bus_wdata = d; bus_req = req;
      #2;
      z = zone(a);
      ecs = {req && !we && z == 0, req && !we && z == 1, req && we && z <= 1,
             req && z == 2, req && z == 4, req && z == 5, req && z == 7};
      acs = {rom_lo_cs, rom_hi_cs, bank_wr, vram_cs, wram0_cs, wram1_cs, io_cs};
      if (!req) begin
         chk(acs == 7'd0, "R12", 32'(acs), 32'd0);
         chk(bus_rdata == 8'h00, "R12", 32'(bus_rdata), 32'd0);
      end else begin
         chk(acs == ecs, tag(z, we), 32'(acs), 32'(ecs));
         if (!we) chk(bus_rdata == exp_read(a), tag(z, we), 32'(bus_rdata), 32'(exp_read(a)));
         else     chk(bus_rdata == 8'h00, "R12", 32'(bus_rdata), 32'd0);
         if (z <= 1) chk(rom_offs == a[13:0], tag(z, we), 32'(rom_offs), 32'(a[13:0]));
         if (z == 2) chk(vram_offs == a[12:0], "R3", 32'(vram_offs), 32'(a[12:0]));
         if (z == 4 || z == 5) chk(wram_offs == a[11:0], tag(z, we), 32'(wram_offs), 32'(a[11:0]));
         if (z == 7) chk(io_offs == a[6:0], "R9", 32'(io_offs), 32'(a[6:0]));
      end
      exp_note = req && we && z == 2;
      @(posedge clk);
      @(negedge clk);
      chk(vram_note == exp_note, "R4", 32'(vram_note), 32'(exp_note));
      if (exp_note) chk(vram_note_offs == a[12:0], "R4", 32'(vram_note_offs), 32'(a[12:0]));
      if (req && we && z == 8) hram_m[a - 16'hFF80] = d;
      if (req && we && z == 9) ie_m = d;
   endtask

   task automatic do_reset();
      bus_req = 1'b0; bus_we = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 127; i++) hram_m[i] = 8'h00;
      ie_m = 8'h00;
      chk(vram_note == 1'b0, "R4", 32'(vram_note), 32'd0);
   endtask

   task automatic scan_top_page();
      for (int i = 0; i < 128; i++) acc(16'hFF80 + 16'(i), 1'b0, 8'h00, 1'b1);
   endtask

   logic [15:0] edges [23] = '{16'h0000, 16'h3FFF, 16'h4000, 16'h7FFF, 16'h8000, 16'h9FFF,
      16'hA000, 16'hBFFF, 16'hC000, 16'hCFFF, 16'hD000, 16'hDFFF, 16'hE000, 16'hEFFF,
      16'hF000, 16'hFDFF, 16'hFE00, 16'hFEFF, 16'hFF00, 16'hFF7F, 16'hFF80, 16'hFFFE, 16'hFFFF};

   initial begin
      #(20ns * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual 0x0 expected 0x1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      @(negedge clk);
      do_reset();
      // R10 R11: everything internal reads zero after reset
      scan_top_page();
      // R11 interrupt-enable write and readback
      acc(16'hFFFF, 1'b1, 8'h5A, 1'b1);
      acc(16'hFFFF, 1'b0, 8'h00, 1'b1);
      // R10 both ends of scratch RAM
      acc(16'hFF80, 1'b1, 8'h3C, 1'b1);
      acc(16'hFFFE, 1'b1, 8'hC7, 1'b1);
      acc(16'hFF80, 1'b0, 8'h00, 1'b1);
      acc(16'hFFFE, 1'b0, 8'h00, 1'b1);
      // R12 write with bus_req low must not land
      acc(16'hFF90, 1'b1, 8'hEE, 1'b0);
      acc(16'hFF90, 1'b0, 8'h00, 1'b1);
      acc(16'hFFFF, 1'b1, 8'h77, 1'b0);
      acc(16'hFFFF, 1'b0, 8'h00, 1'b1);
      // R5 R8 stub writes ignored, R4 pulse drops after one cycle
      acc(16'hA123, 1'b1, 8'hFF, 1'b1);
      acc(16'hA123, 1'b0, 8'h00, 1'b1);
      acc(16'hFE40, 1'b1, 8'hFF, 1'b1);
      acc(16'hFE40, 1'b0, 8'h00, 1'b1);
      acc(16'h9ABC, 1'b1, 8'h12, 1'b1);
      acc(16'h8001, 1'b1, 8'h34, 1'b1);
      acc(16'h8001, 1'b0, 8'h00, 1'b1);
      // every region edge, read and write
      foreach (edges[k]) begin
         acc(edges[k], 1'b0, 8'h00, 1'b1);
         acc(edges[k], 1'b1, 8'(k * 7 + 3), 1'b1);
         acc(edges[k], 1'b0, 8'h00, 1'b1);
      end
      // constrained random traffic
      for (int n = 0; n < 3000; n++) begin
         int sel;
         logic [15:0] a;
         sel = int'($urandom_range(0, 9));
         if (sel < 4)      a = 16'($urandom);
         else if (sel < 7) a = {8'hFF, 8'($urandom)};
         else if (sel < 8) a = {8'hFE, 8'($urandom)} ^ 16'h0100;
         else              a = edges[$urandom_range(0, 22)];
         acc(a, 1'($urandom), 8'($urandom), ($urandom_range(0, 7) != 0));
      end
      // R10 a second reset clears what the traffic stored
      do_reset();
      scan_top_page();
      bus_req = 1'b0;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule